// File: doc/BRIEF.md
# Partitioned Byte-by-Coefficient Fixed-Point Multiplier

This block multiplies unsigned 8-bit pixel components by signed 16-bit fixed-point coefficients, several lanes at a time, and returns one rounded 16-bit value per lane. A 9-bit opcode picks the lane arrangement. Each byte can have its own coefficient, or all four bytes can share one coefficient taken from either half of the second operand. The multiplicand can be the high or the low byte of each 16-bit lane. A double form computes two lanes and places each result in its own 32-bit half of the output.

Every lane forms the exact product of the zero-extended byte and the sign-extended coefficient. It keeps the middle sixteen bits of that product and adds one when the bit just below them is set. The operation issues with `in_valid` and returns one cycle later with `out_valid`. An opcode outside the supported set returns a zero result with an error flag.

Top module: `pmul8x16`

## Requirements
- R1: `out_valid` is high in the cycle after each cycle in which `in_valid` is high, and low otherwise, so back-to-back operations each return one cycle after issue.
- R2: Each lane computes p = zero-extend(byte) × sign-extend(coef) (at least 25 bits). Its 16-bit result is p[23:8] + p[7], wrapping modulo 2^16. For example, byte 0x01 with coefficient 0xFF80 gives 0x0000.
- R3: With opcode 0x031, lane i (i = 0..3) multiplies byte `src_a[8i+7:8i]` by `src_b[16i+15:16i]` and writes `result[16i+15:16i]`.
- R4: With opcodes 0x033 and 0x035, lane i multiplies `src_a[8i+7:8i]` by one shared coefficient, `src_b[31:16]` for 0x033 or `src_b[15:0]` for 0x035, and writes `result[16i+15:16i]`.
- R5: With opcodes 0x036 and 0x037, lane i multiplies `src_a[16i+15:16i+8]` (0x036) or `src_a[16i+7:16i]` (0x037) by `src_b[16i+15:16i]` and writes `result[16i+15:16i]`.
- R6: With opcodes 0x038 and 0x039, only lanes 0 and 1 are formed. They use the same byte choice as 0x036 and 0x037 respectively, and each lane's 16-bit value is placed at `result[32i+22:32i+7]`. All other result bits are zero.
- R7: Any other opcode returns a zero result with `bad_op` high. A supported opcode returns `bad_op` low.
- R8: While `in_valid` is low, `result` and `bad_op` hold their last values.
- R9: After reset, `out_valid`, `result` and `bad_op` are zero.
- R10: `src_a[63:32]` has no effect for opcodes 0x031, 0x033, 0x035, 0x038 and 0x039. `src_b[63:32]` has no effect for opcodes 0x033, 0x035, 0x038 and 0x039.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation issue strobe |
| opcode | input | 9 | Lane arrangement select |
| src_a | input | 64 | Byte operand |
| src_b | input | 64 | Coefficient operand |
| out_valid | output | 1 | Result valid, one cycle after issue |
| result | output | 64 | Packed lane results |
| bad_op | output | 1 | Unsupported opcode flag for the current result |

## Verification
The hardest case to reach is the rounding wrap. Here a small negative product has all ones in its middle bits and a set rounding bit, so the increment carries out and the lane becomes zero. Random operands almost never produce this, so directed operations drive byte 1 against coefficient 0xFF80 and similar values, alongside the largest positive and negative products. A pair of runs that differ only in the ignored upper operand halves shows that those bits have no effect.

// File: rtl/pmul_pkg.sv
package pmul_pkg;

    localparam int DATA_W = 64;
    localparam int OPC_W  = 9;
    localparam int LANES  = 4;
    localparam int BYTE_W = 8;
    localparam int COEF_W = 16;
    localparam int PROD_W = BYTE_W + COEF_W + 1;
    localparam int RES_W  = COEF_W;
    localparam int DBL_LANES = LANES / 2;
    localparam int DBL_SHIFT = 7;
    localparam int HALF_W = DATA_W / 2;

    localparam logic [OPC_W-1:0] OPC_PER_LANE  = 9'h031;
    localparam logic [OPC_W-1:0] OPC_SHARED_HI = 9'h033;
    localparam logic [OPC_W-1:0] OPC_SHARED_LO = 9'h035;
    localparam logic [OPC_W-1:0] OPC_HI_BYTES  = 9'h036;
    localparam logic [OPC_W-1:0] OPC_LO_BYTES  = 9'h037;
    localparam logic [OPC_W-1:0] OPC_DBL_HI    = 9'h038;
    localparam logic [OPC_W-1:0] OPC_DBL_LO    = 9'h039;

    typedef enum logic [1:0] {
        BSEL_PACKED  = 2'd0,
        BSEL_HI_HALF = 2'd1,
        BSEL_LO_HALF = 2'd2
    } byte_sel_e;

    typedef enum logic [1:0] {
        CSEL_PER_LANE = 2'd0,
        CSEL_SHARE_HI = 2'd1,
        CSEL_SHARE_LO = 2'd2
    } coef_sel_e;

    typedef struct packed {
        logic      known;
        byte_sel_e bsel;
        coef_sel_e csel;
        logic      dbl;
    } op_ctl_t;

    typedef logic [LANES-1:0][BYTE_W-1:0] lane_bytes_t;
    typedef logic [LANES-1:0][COEF_W-1:0] lane_coefs_t;
    typedef logic [LANES-1:0][RES_W-1:0]  lane_res_t;

    function automatic op_ctl_t decode_op(input logic [OPC_W-1:0] opc);
        op_ctl_t c;
        c = '{known: 1'b1, bsel: BSEL_PACKED, csel: CSEL_PER_LANE, dbl: 1'b0};
        case (opc)
            OPC_PER_LANE:  ;
            OPC_SHARED_HI: c.csel = CSEL_SHARE_HI;
            OPC_SHARED_LO: c.csel = CSEL_SHARE_LO;
            OPC_HI_BYTES:  c.bsel = BSEL_HI_HALF;
            OPC_LO_BYTES:  c.bsel = BSEL_LO_HALF;
            OPC_DBL_HI: begin
                c.bsel = BSEL_HI_HALF;
                c.dbl  = 1'b1;
            end
            OPC_DBL_LO: begin
                c.bsel = BSEL_LO_HALF;
                c.dbl  = 1'b1;
            end
            default: c.known = 1'b0;
        endcase
        return c;
    endfunction

    function automatic logic [RES_W-1:0] round_mid(input logic [PROD_W-1:0] p);
        return p[BYTE_W +: RES_W] + {{(RES_W-1){1'b0}}, p[BYTE_W-1]};
    endfunction

endpackage

// File: rtl/pmul_operand_sel.sv
module pmul_operand_sel
    import pmul_pkg::*;
(
    input  op_ctl_t           ctl,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output lane_bytes_t       bytes,
    output lane_coefs_t       coefs
);
    localparam int LANE_W = DATA_W / LANES;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_comb begin
            case (ctl.bsel)
                BSEL_HI_HALF: bytes[i] = src_a[LANE_W*i + BYTE_W +: BYTE_W];
                BSEL_LO_HALF: bytes[i] = src_a[LANE_W*i +: BYTE_W];
                default:      bytes[i] = src_a[BYTE_W*i +: BYTE_W];
            endcase
            case (ctl.csel)
                CSEL_SHARE_HI: coefs[i] = src_b[COEF_W +: COEF_W];
                CSEL_SHARE_LO: coefs[i] = src_b[0 +: COEF_W];
                default:       coefs[i] = src_b[LANE_W*i +: COEF_W];
            endcase
        end
    end
endmodule

// File: rtl/pmul_lane.sv
module pmul_lane
    import pmul_pkg::*;
(
    input  logic [BYTE_W-1:0] mcand,
    input  logic [COEF_W-1:0] coef,
    output logic [RES_W-1:0]  rounded
);
    logic signed [PROD_W-1:0] ext_byte;
    logic signed [PROD_W-1:0] ext_coef;
    logic signed [PROD_W-1:0] prod;

    always_comb begin
        ext_byte = $signed({{(PROD_W-BYTE_W){1'b0}}, mcand});
        ext_coef = $signed({{(PROD_W-COEF_W){coef[COEF_W-1]}}, coef});
        prod     = ext_byte * ext_coef;
        rounded  = round_mid(prod);
    end
endmodule

// File: rtl/pmul_pack.sv
module pmul_pack
    import pmul_pkg::*;
(
    input  op_ctl_t           ctl,
    input  lane_res_t         lanes,
    output logic [DATA_W-1:0] packed_res
);
    always_comb begin
        packed_res = '0;
        if (ctl.known) begin
            if (ctl.dbl) begin
                for (int i = 0; i < DBL_LANES; i++)
                    packed_res[HALF_W*i + DBL_SHIFT +: RES_W] = lanes[i];
            end else begin
                for (int i = 0; i < LANES; i++)
                    packed_res[RES_W*i +: RES_W] = lanes[i];
            end
        end
    end
endmodule

// File: rtl/pmul8x16.sv
module pmul8x16
    import pmul_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [OPC_W-1:0]  opcode,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              bad_op
);
    op_ctl_t           ctl;
    lane_bytes_t       bytes;
    lane_coefs_t       coefs;
    lane_res_t         lane_out;
    logic [DATA_W-1:0] packed_res;

    assign ctl = decode_op(opcode);

    pmul_operand_sel u_sel (
        .ctl   (ctl),
        .src_a (src_a),
        .src_b (src_b),
        .bytes (bytes),
        .coefs (coefs)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_mul
        pmul_lane u_lane (
            .mcand   (bytes[i]),
            .coef    (coefs[i]),
            .rounded (lane_out[i])
        );
    end

    pmul_pack u_pack (
        .ctl        (ctl),
        .lanes      (lane_out),
        .packed_res (packed_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
            bad_op    <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= packed_res;
                bad_op <= ~ctl.known;
            end
        end
    end
endmodule

// File: rtl/pmul8x16_check.sv
module pmul8x16_check
    import pmul_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [OPC_W-1:0]  opcode,
    input logic [DATA_W-1:0] src_a,
    input logic [DATA_W-1:0] src_b,
    input logic              out_valid,
    input logic [DATA_W-1:0] result,
    input logic              bad_op
);
    localparam logic [DATA_W-1:0] DBL_KEEP =
        ({{(DATA_W-RES_W){1'b0}}, {RES_W{1'b1}}} << DBL_SHIFT) |
        ({{(DATA_W-RES_W){1'b0}}, {RES_W{1'b1}}} << (HALF_W + DBL_SHIFT));

    logic supported;
    assign supported = (opcode == OPC_PER_LANE)  || (opcode == OPC_SHARED_HI) ||
                       (opcode == OPC_SHARED_LO) || (opcode == OPC_HI_BYTES)  ||
                       (opcode == OPC_LO_BYTES)  || (opcode == OPC_DBL_HI)    ||
                       (opcode == OPC_DBL_LO);

    assert_issue_returns_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_shared_zero_coef_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && opcode == OPC_SHARED_HI && src_b[COEF_W +: COEF_W] == '0) |=> (result == '0));

    assert_dbl_gaps_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (opcode == OPC_DBL_HI || opcode == OPC_DBL_LO)) |=> ((result & ~DBL_KEEP) == '0));

    assert_bad_flag_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !supported) |=> (bad_op && result == '0));

    assert_good_no_flag_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && supported) |=> !bad_op);

    assert_hold_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(result) && $stable(bad_op)));
endmodule

bind pmul8x16 pmul8x16_check u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .opcode    (opcode),
    .src_a     (src_a),
    .src_b     (src_b),
    .out_valid (out_valid),
    .result    (result),
    .bad_op    (bad_op)
);

// File: tb/sim_pmul8x16.sv
module sim_pmul8x16;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [8:0]  opcode = '0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic        out_valid;
    logic [63:0] result;
    logic        bad_op;

    int n_tests = 0;
    int n_fail  = 0;
    bit ended   = 0;

    always #5 clk = ~clk;

    pmul8x16 u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode),
        .src_a(src_a), .src_b(src_b),
        .out_valid(out_valid), .result(result), .bad_op(bad_op)
    );

    function automatic logic [15:0] ref_lane(input logic [7:0] u, input logic [15:0] c);
        longint      p;
        logic [63:0] q;
        p = longint'(u) * longint'($signed(c));
        q = p;
        return q[23:8] + {15'b0, q[7]};
    endfunction

    function automatic logic [64:0] ref_op(input logic [8:0] op, input logic [63:0] a, input logic [63:0] b);
        logic [63:0] r;
        logic        e;
        r = '0;
        e = 1'b0;
        case (op)
            9'h031: for (int i = 0; i < 4; i++) r[16*i +: 16] = ref_lane(a[8*i +: 8], b[16*i +: 16]);
            9'h033: for (int i = 0; i < 4; i++) r[16*i +: 16] = ref_lane(a[8*i +: 8], b[31:16]);
            9'h035: for (int i = 0; i < 4; i++) r[16*i +: 16] = ref_lane(a[8*i +: 8], b[15:0]);
            9'h036: for (int i = 0; i < 4; i++) r[16*i +: 16] = ref_lane(a[16*i+8 +: 8], b[16*i +: 16]);
            9'h037: for (int i = 0; i < 4; i++) r[16*i +: 16] = ref_lane(a[16*i +: 8], b[16*i +: 16]);
            9'h038: for (int i = 0; i < 2; i++) r[32*i+7 +: 16] = ref_lane(a[16*i+8 +: 8], b[16*i +: 16]);
            9'h039: for (int i = 0; i < 2; i++) r[32*i+7 +: 16] = ref_lane(a[16*i +: 8], b[16*i +: 16]);
            default: e = 1'b1;
        endcase
        return {e, r};
    endfunction

    function automatic string req_of(input logic [8:0] op);
        case (op)
            9'h031: return "R3";
            9'h033, 9'h035: return "R4";
            9'h036, 9'h037: return "R5";
            9'h038, 9'h039: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string req, input logic [65:0] got, input logic [65:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic issue(input logic [8:0] op, input logic [63:0] a, input logic [63:0] b);
        in_valid = 1'b1;
        opcode   = op;
        src_a    = a;
        src_b    = b;
    endtask

    task automatic run_op(input logic [8:0] op, input logic [63:0] a, input logic [63:0] b, input string req);
        @(negedge clk);
        issue(op, a, b);
        @(negedge clk);
        in_valid = 1'b0;
        check(req, {out_valid, bad_op, result}, {1'b1, ref_op(op, a, b)});
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [8:0]  ops[7];
        logic [63:0] keep_res;
        logic        keep_bad;
        ops = '{9'h031, 9'h033, 9'h035, 9'h036, 9'h037, 9'h038, 9'h039};
        void'($urandom(32'd20240613));

        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9", {out_valid, bad_op, result}, 66'd0);
        rst = 1'b0;

        // R2: rounding carry wraps to zero
        run_op(9'h031, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_FF80, "R2");
        check("R2", {50'd0, result[15:0]}, 66'd0);
        // R2: largest positive and negative products, mid-point rounding
        run_op(9'h031, 64'h0000_0000_80FF_FFFF, 64'h0080_8000_8000_7FFF, "R2");
        run_op(9'h037, 64'h0000_0080_0001_00FF, 64'h0100_FFFF_0001_8000, "R2");

        // R3..R6 directed
        run_op(9'h031, 64'hDEAD_BEEF_0403_0201, 64'h0400_0300_0200_0100, "R3");
        run_op(9'h033, 64'h0000_0000_FF80_4010, 64'h1234_5678_C000_7FFF, "R4");
        run_op(9'h035, 64'h0000_0000_FF80_4010, 64'h1234_5678_C000_7FFF, "R4");
        run_op(9'h036, 64'hFF00_8000_0100_7F00, 64'h8000_7FFF_1234_0200, "R5");
        run_op(9'h037, 64'h00FF_0080_0001_007F, 64'h8000_7FFF_1234_0200, "R5");
        run_op(9'h038, 64'h0000_0000_FF00_8000, 64'h0000_0000_8000_7FFF, "R6");
        run_op(9'h039, 64'h0000_0000_00FF_0080, 64'h0000_0000_FFFF_0100, "R6");

        // R7: unsupported opcodes
        run_op(9'h032, 64'hFFFF_FFFF_FFFF_FFFF, 64'h7FFF_7FFF_7FFF_7FFF, "R7");
        run_op(9'h000, 64'h0101_0101_0101_0101, 64'h0100_0100_0100_0100, "R7");

        // R8: hold while idle
        run_op(9'h036, 64'h1122_3344_5566_7788, 64'h0F0F_F0F0_1234_8765, "R8");
        keep_res = result;
        keep_bad = bad_op;
        repeat (3) begin
            @(negedge clk);
            opcode = 9'h1FF;
            src_a  = {$urandom, $urandom};
            src_b  = {$urandom, $urandom};
        end
        check("R8", {out_valid, keep_bad, result}, {1'b0, bad_op, keep_res});

        // R10: upper operand halves have no effect
        begin
            logic [8:0]  r10_ops[5];
            logic [63:0] base_res;
            r10_ops = '{9'h031, 9'h033, 9'h035, 9'h038, 9'h039};
            for (int k = 0; k < 5; k++) begin
                logic [31:0] la, lb;
                la = $urandom;
                lb = $urandom;
                run_op(r10_ops[k], {32'd0, la}, {32'd0, lb}, "R10");
                base_res = result;
                if (r10_ops[k] == 9'h031)
                    run_op(r10_ops[k], {$urandom, la}, {32'd0, lb}, "R10");
                else
                    run_op(r10_ops[k], {$urandom, la}, {$urandom, lb}, "R10");
                check("R10", {2'b00, result}, {2'b00, base_res});
            end
        end

        // R1: back-to-back issue
        begin
            logic [63:0] a1, b1, a2, b2;
            a1 = {$urandom, $urandom}; b1 = {$urandom, $urandom};
            a2 = {$urandom, $urandom}; b2 = {$urandom, $urandom};
            @(negedge clk);
            issue(9'h031, a1, b1);
            @(negedge clk);
            check("R1", {out_valid, bad_op, result}, {1'b1, ref_op(9'h031, a1, b1)});
            issue(9'h039, a2, b2);
            @(negedge clk);
            check("R1", {out_valid, bad_op, result}, {1'b1, ref_op(9'h039, a2, b2)});
            in_valid = 1'b0;
            @(negedge clk);
            check("R1", {65'd0, out_valid}, 66'd0);
        end

        // Random mix
        for (int n = 0; n < 400; n++) begin
            logic [8:0]  op;
            logic [63:0] a, b;
            op = ($urandom % 10 == 0) ? 9'($urandom) : ops[$urandom % 7];
            a  = {$urandom, $urandom};
            b  = {$urandom, $urandom};
            run_op(op, a, b, req_of(op));
            if ($urandom % 4 == 0) @(negedge clk);
        end

        finish_run();
    end
endmodule